// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Model

This block is a clocked, synthesizable model of a 2K x 8 nonvolatile memory. Its pin interface looks like an asynchronous static RAM: active-low chip select, output enable and write strobe, an 11-bit address, and a data bus split into input, output and output-enable signals. All control inputs are sampled on the rising clock edge. A byte write is not finished when the strobe ends. The model latches the target address and byte and then runs an internal timer. For that whole period the ready output stays low, and any read returns a status byte instead of stored data.

Writes are refused in three cases: output enable is low during the strobe, the block is inside its power-up lockout window after reset, or a previous operation is still running. A separate identification store of 32 bytes sits at the top 32 addresses and is reached while the identification-select input is high. A chip-clear command fills the main array with ones. The command is chip select low plus the clear-select input, held together with a long write-strobe pulse. The clear visits one address per clock. All durations are parameters counted in clock cycles, so a simulation can shrink them.

Top module: `stbw_mem`

## Requirements
- R1: When cs_n=0, oe_n=0, we_n=1 and ready=1, dout_en is 1 and dout equals the byte stored at the addressed location.
- R2: dout_en is 0 whenever cs_n or oe_n is high.
- R3: A write strobe is active while cs_n=0, we_n=0, oe_n=1 and clr_sel=0. The address (and id_sel) is taken on the first clock edge on which the strobe is active. The data is the din value sampled on the last active edge. The write is committed on the first edge on which the strobe is no longer active.
- R4: After a commit, ready is 0 for exactly WRITE_CYC clock cycles. The new byte is readable once ready returns to 1.
- R5: While ready is 0, a read (cs_n=0, oe_n=0, we_n=1) drives dout_en=1. dout[7] is the inverse of bit 7 of the byte being written (1 during a clear), and dout[6:0] are 0.
- R6: A strobe with oe_n=0, or a we_n pulse with cs_n=1, starts nothing: ready stays 1 and memory is unchanged.
- R7: For the first PWRUP_CYC clock edges after reset, write strobes are ignored and ready stays 1.
- R8: Write or clear strobes that begin while ready is 0 are ignored. They are not queued and do not change the running operation.
- R9: With id_sel=1, addresses 0x7E0 to 0x7FF read and write a separate 32-byte store, leaving the main array untouched. With id_sel=1, lower addresses reach the main array.
- R10: When cs_n=0, we_n=0 and clr_sel=1 are held for CLEAR_HOLD consecutive edges, ready falls after the CLEAR_HOLD-th edge. It then stays 0 for 2048 cycles while every main-array byte is set to 0xFF, and the identification store is kept.
- R11: A clear command released before CLEAR_HOLD edges has no effect: ready stays 1 and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| clr_sel | input | 1 | Clear-command select (digital stand-in for a high-voltage level) |
| id_sel | input | 1 | Identification-store select |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Data bus drive enable |
| ready | output | 1 | High when idle, low while a write or clear runs |

## Verification
Writes are driven with three strobe shapes: a short we_n pulse, a pulse gated by cs_n where the address and data change while the strobe is active, and a pulse whose start is made invalid by oe_n low or cs_n high. Together these separate correct capture of the first address and the last data from a design that tracks the bus until commit. Status reads during busy periods use bytes with bit 7 both set and clear, which shows true inversion rather than a constant. Further cases check that busy length is unaffected by a second strobe arriving mid-write, and that a cancelled clear leaves memory intact while a full clear rewrites the main array but not the identification store.

// File: rtl/stbw_pkg.sv
package stbw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WR   = 2'd1,
      ST_CLR  = 2'd2
   } seq_st_t;

   function automatic int unsigned cnt_w(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/stbw_strobe.sv
module stbw_strobe #(
   parameter int unsigned ADDR_W     = 11,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CLEAR_HOLD = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              clr_sel,
   input  logic              id_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              allow_i,
   output logic              start_o,
   output logic              clr_go_o,
   output logic [ADDR_W-1:0] pend_addr_o,
   output logic              pend_id_o,
   output logic [DATA_W-1:0] pend_data_o
);
   import stbw_pkg::*;

   localparam int unsigned HW = cnt_w(CLEAR_HOLD);

   if (CLEAR_HOLD < 2) begin : g_bad_hold
      initial $fatal(1, "stbw_strobe: CLEAR_HOLD must be at least 2");
   end

   logic          wr_act, clr_act;
   logic          act_q, armed_q;
   logic [HW-1:0] hold_q;
   logic          hold_full;

   assign wr_act    = !cs_n && !we_n && oe_n && !clr_sel;
   assign clr_act   = !cs_n && !we_n && clr_sel;
   assign hold_full = (hold_q == HW'(CLEAR_HOLD - 1));

   // strobe tracking: address on first active edge, data on every armed edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         armed_q     <= 1'b0;
         pend_addr_o <= '0;
         pend_id_o   <= 1'b0;
         pend_data_o <= '0;
      end else begin
         act_q <= wr_act;
         if (wr_act && !act_q) begin
            armed_q <= allow_i;
            if (allow_i) begin
               pend_addr_o <= addr;
               pend_id_o   <= id_sel;
               pend_data_o <= din;
            end
         end else if (wr_act && armed_q) begin
            pend_data_o <= din;
         end else if (!wr_act) begin
            armed_q <= 1'b0;
         end
      end
   end

   assign start_o = act_q && !wr_act && armed_q;

   // clear command must be held for CLEAR_HOLD consecutive edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (!clr_act || !allow_i) begin
         hold_q <= '0;
      end else if (!hold_full) begin
         hold_q <= hold_q + HW'(1);
      end
   end

   assign clr_go_o = clr_act && allow_i && hold_full;

   p_clr_go_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_go_o |-> $past(clr_act));

   p_data_stable_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!allow_i && !(wr_act && armed_q)) |=> $stable(pend_data_o));

endmodule

// File: rtl/stbw_seq.sv
module stbw_seq #(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned WRITE_CYC = 125000,
   parameter int unsigned PWRUP_CYC = 625000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clr_go_i,
   output logic              allow_o,
   output logic              ready_o,
   output logic              clearing_o,
   output logic              commit_o,
   output logic              clr_we_o,
   output logic [ADDR_W-1:0] clr_addr_o
);
   import stbw_pkg::*;

   localparam int unsigned TW = cnt_w(WRITE_CYC);
   localparam int unsigned PW = $clog2(PWRUP_CYC + 1);

   if (WRITE_CYC < 2) begin : g_bad_wr
      initial $fatal(1, "stbw_seq: WRITE_CYC must be at least 2");
   end
   if (PWRUP_CYC < 1) begin : g_bad_pw
      initial $fatal(1, "stbw_seq: PWRUP_CYC must be at least 1");
   end

   seq_st_t           st_q;
   logic [TW-1:0]     tmr_q;
   logic [PW-1:0]     pw_q;
   logic [ADDR_W-1:0] clr_addr_q;
   logic              unlocked;
   logic              tmr_done, sweep_done;

   assign unlocked   = (pw_q == PW'(PWRUP_CYC));
   assign tmr_done   = (tmr_q == TW'(WRITE_CYC - 1));
   assign sweep_done = (clr_addr_q == {ADDR_W{1'b1}});

   // power-up lockout counter, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pw_q <= '0;
      else if (!unlocked) pw_q <= pw_q + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         tmr_q      <= '0;
         clr_addr_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q  <= ST_WR;
                  tmr_q <= '0;
               end else if (clr_go_i) begin
                  st_q       <= ST_CLR;
                  clr_addr_q <= '0;
               end
            end
            ST_WR: begin
               if (tmr_done) st_q  <= ST_IDLE;
               else          tmr_q <= tmr_q + TW'(1);
            end
            ST_CLR: begin
               if (sweep_done) st_q       <= ST_IDLE;
               else            clr_addr_q <= clr_addr_q + ADDR_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign allow_o    = unlocked && (st_q == ST_IDLE);
   assign ready_o    = (st_q == ST_IDLE);
   assign clearing_o = (st_q == ST_CLR);
   assign commit_o   = (st_q == ST_WR) && tmr_done;
   assign clr_we_o   = (st_q == ST_CLR);
   assign clr_addr_o = clr_addr_q;

   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || clr_go_i) |-> (st_q == ST_IDLE && unlocked));

   p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> ready_o);

   p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!ready_o && tmr_q == '0));

   p_sweep_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CLR && $past(st_q) == ST_CLR) |->
         (clr_addr_q == $past(clr_addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/stbw_array.sv
module stbw_array #(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ID_BYTES = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_id,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_id,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] main_mem [DEPTH];
   logic              wr_hit, rd_hit;
   logic [DATA_W-1:0] id_rd;

   if (ID_BYTES > 0) begin : g_id
      localparam int unsigned IAW     = (ID_BYTES < 2) ? 1 : $clog2(ID_BYTES);
      localparam int unsigned ID_BASE = DEPTH - ID_BYTES;

      if ((1 << IAW) != ID_BYTES || ID_BYTES > DEPTH) begin : g_bad_id
         initial $fatal(1, "stbw_array: ID_BYTES must be a power of two within the array");
      end

      logic [DATA_W-1:0] id_mem [ID_BYTES];

      assign wr_hit = wr_id && (int'(wr_addr) >= ID_BASE);
      assign rd_hit = rd_id && (int'(rd_addr) >= ID_BASE);

      always_ff @(posedge clk) begin
         if (wr_en && wr_hit) id_mem[wr_addr[IAW-1:0]] <= wr_data;
      end

      assign id_rd = id_mem[rd_addr[IAW-1:0]];
   end else begin : g_no_id
      logic unused_id;
      assign unused_id = wr_id ^ rd_id;
      assign wr_hit    = 1'b0;
      assign rd_hit    = 1'b0;
      assign id_rd     = '0;
   end

   always_ff @(posedge clk) begin
      if (clr_en)                main_mem[clr_addr] <= {DATA_W{1'b1}};
      else if (wr_en && !wr_hit) main_mem[wr_addr]  <= wr_data;
   end

   assign rd_data = rd_hit ? id_rd : main_mem[rd_addr];

endmodule

// File: rtl/stbw_mem.sv
module stbw_mem #(
   parameter int unsigned ADDR_W     = 11,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ID_BYTES   = 32,
   parameter int unsigned WRITE_CYC  = 125000,
   parameter int unsigned PWRUP_CYC  = 625000,
   parameter int unsigned CLEAR_HOLD = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              clr_sel,
   input  logic              id_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              ready
);
   if (DATA_W < 2) begin : g_bad_dw
      initial $fatal(1, "stbw_mem: DATA_W must be at least 2");
   end

   logic              allow, start, clr_go, clearing, commit, clr_we;
   logic [ADDR_W-1:0] pend_addr, clr_addr;
   logic              pend_id;
   logic [DATA_W-1:0] pend_data, rd_data;
   logic              rd_req, poll_bit;

   stbw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_HOLD(CLEAR_HOLD)) u_strobe (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .clr_sel(clr_sel), .id_sel(id_sel), .addr(addr), .din(din),
      .allow_i(allow), .start_o(start), .clr_go_o(clr_go),
      .pend_addr_o(pend_addr), .pend_id_o(pend_id), .pend_data_o(pend_data)
   );

   stbw_seq #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .PWRUP_CYC(PWRUP_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .clr_go_i(clr_go),
      .allow_o(allow), .ready_o(ready), .clearing_o(clearing),
      .commit_o(commit), .clr_we_o(clr_we), .clr_addr_o(clr_addr)
   );

   stbw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES)) u_array (
      .clk(clk), .wr_en(commit), .wr_addr(pend_addr), .wr_id(pend_id),
      .wr_data(pend_data), .clr_en(clr_we), .clr_addr(clr_addr),
      .rd_addr(addr), .rd_id(id_sel), .rd_data(rd_data)
   );

   // read path: stored data when idle, inverted top bit as status when busy
   assign rd_req   = !cs_n && !oe_n && we_n;
   assign poll_bit = clearing ? 1'b1 : pend_data[DATA_W-1];
   assign dout_en  = rd_req;

   always_comb begin
      if (!rd_req)    dout = '0;
      else if (ready) dout = rd_data;
      else            dout = {~poll_bit, {(DATA_W-1){1'b0}}};
   end

   p_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !cs_n && !oe_n && we_n) |-> (dout_en && dout[DATA_W-2:0] == '0));

   p_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || oe_n) |-> (!dout_en && dout == '0));

endmodule

// File: tb/stbw_mem_tb.sv
`timescale 1ns/1ps
module stbw_mem_tb;
   localparam int W  = 20;
   localparam int PU = 30;
   localparam int H  = 16;
   localparam int DEPTH = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, clr_sel = 1'b0, id_sel = 1'b0;
   logic [10:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en, ready;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   stbw_mem #(.WRITE_CYC(W), .PWRUP_CYC(PU), .CLEAR_HOLD(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .clr_sel(clr_sel), .id_sel(id_sel), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en), .ready(ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; clr_sel = 1'b0; id_sel = 1'b0;
   endtask

   // one-cycle we_n pulse; returns just before the commit edge
   task automatic pulse_write(input logic [10:0] a, input logic id, input logic [7:0] d);
      @(negedge clk);
      addr = a; id_sel = id; din = d; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1; cs_n = 1'b1; id_sel = 1'b0;
   endtask

   // counts cycles with ready low, starting after the next edge
   task automatic busy_len(output int n);
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #2;
         if (!ready) n++;
         else break;
      end
   endtask

   task automatic write_byte(input logic [10:0] a, input logic id, input logic [7:0] d);
      int n;
      pulse_write(a, id, d);
      busy_len(n);
   endtask

   task automatic read_chk(input string req, input logic [10:0] a, input logic id,
                           input logic [7:0] exp);
      @(negedge clk);
      addr = a; id_sel = id; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk({req, " dout_en"}, int'(dout_en), 1);
      chk({req, " data"}, int'(dout), int'(exp));
      @(negedge clk);
      idle_bus();
   endtask

   task automatic ready_stays(input string req, input int cyc);
      int low = 0;
      for (int i = 0; i < cyc; i++) begin
         @(posedge clk); #2;
         if (!ready) low++;
      end
      chk(req, low, 0);
   endtask

   task automatic t_reset();
      #1;
      chk("R2 reset dout_en", int'(dout_en), 0);
      chk("R4 reset ready", int'(ready), 1);
   endtask

   task automatic t_lockout();
      pulse_write(11'h005, 1'b0, 8'h77);
      ready_stays("R7 lockout write ignored", 6);
      repeat (PU + 5) @(negedge clk);
   endtask

   task automatic t_write_poll(input logic [10:0] a, input logic [7:0] d, input logic [7:0] poll);
      int n;
      pulse_write(a, 1'b0, d);
      @(posedge clk); #1;
      cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk("R5 poll dout_en", int'(dout_en), 1);
      chk("R5 poll value", int'(dout), int'(poll));
      n = (!ready) ? 1 : 0;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #2;
         if (!ready) n++;
         else break;
      end
      chk("R4 busy length", n, W);
      @(negedge clk);
      idle_bus();
      read_chk("R1 read after write", a, 1'b0, d);
   endtask

   task automatic t_latch();
      int n;
      write_byte(11'h020, 1'b0, 8'h00);
      write_byte(11'h021, 1'b0, 8'h00);
      write_byte(11'h022, 1'b0, 8'h00);
      @(negedge clk);
      addr = 11'h020; din = 8'h99; oe_n = 1'b1; we_n = 1'b0; cs_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b0; addr = 11'h021;
      @(negedge clk);
      addr = 11'h022; din = 8'h5B;
      @(negedge clk);
      cs_n = 1'b1; din = 8'hEE;
      @(negedge clk);
      we_n = 1'b1;
      busy_len(n);
      read_chk("R3 later-fall address gets data", 11'h021, 1'b0, 8'h5B);
      read_chk("R3 earlier address untouched", 11'h020, 1'b0, 8'h00);
      read_chk("R3 mid-pulse address untouched", 11'h022, 1'b0, 8'h00);
   endtask

   task automatic t_inhibit();
      @(negedge clk);
      addr = 11'h010; din = 8'h00; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      repeat (3) @(negedge clk);
      idle_bus();
      ready_stays("R6 oe_n low inhibits", 6);
      @(negedge clk);
      addr = 11'h010; din = 8'h00; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
      repeat (3) @(negedge clk);
      idle_bus();
      ready_stays("R6 cs_n high inhibits", 6);
      read_chk("R6 byte unchanged", 11'h010, 1'b0, 8'hA5);
   endtask

   task automatic t_busy_ignore();
      int n;
      write_byte(11'h031, 1'b0, 8'h00);
      pulse_write(11'h030, 1'b0, 8'h11);
      @(posedge clk); #2;
      n = (!ready) ? 1 : 0;
      @(negedge clk);
      addr = 11'h031; din = 8'hFF; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
      @(posedge clk); #2; if (!ready) n++;
      @(negedge clk);
      we_n = 1'b1; cs_n = 1'b1;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #2;
         if (!ready) n++;
         else break;
      end
      chk("R8 busy length unchanged", n, W);
      ready_stays("R8 no queued write", 5);
      read_chk("R8 second target untouched", 11'h031, 1'b0, 8'h00);
      read_chk("R8 first write landed", 11'h030, 1'b0, 8'h11);
   endtask

   task automatic t_id();
      write_byte(11'h7E5, 1'b1, 8'h11);
      write_byte(11'h7E5, 1'b0, 8'h22);
      read_chk("R9 id store", 11'h7E5, 1'b1, 8'h11);
      read_chk("R9 main at same address", 11'h7E5, 1'b0, 8'h22);
      read_chk("R9 id_sel low address hits main", 11'h005, 1'b1, 8'h12);
   endtask

   task automatic t_clear_short();
      @(negedge clk);
      cs_n = 1'b0; clr_sel = 1'b1; oe_n = 1'b1; we_n = 1'b0;
      repeat (H / 2) @(negedge clk);
      idle_bus();
      ready_stays("R11 short clear no busy", 4);
      read_chk("R11 data kept", 11'h010, 1'b0, 8'hA5);
   endtask

   task automatic t_clear();
      int k;
      int n;
      @(negedge clk);
      cs_n = 1'b0; clr_sel = 1'b1; oe_n = 1'b1; we_n = 1'b0;
      k = 0;
      for (int i = 0; i < 100; i++) begin
         @(posedge clk); #2;
         k++;
         if (!ready) break;
      end
      chk("R10 clear start edge", k, H);
      n = 1;
      @(negedge clk);
      we_n = 1'b1; clr_sel = 1'b0; oe_n = 1'b0;
      #1;
      chk("R5 clear poll value", int'(dout), 0);
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk); #2;
         if (!ready) n++;
         else break;
      end
      chk("R10 sweep length", n, DEPTH);
      @(negedge clk);
      idle_bus();
      read_chk("R10 cleared low", 11'h000, 1'b0, 8'hFF);
      read_chk("R10 cleared written", 11'h010, 1'b0, 8'hFF);
      read_chk("R10 cleared top", 11'h7FF, 1'b0, 8'hFF);
      read_chk("R10 id kept", 11'h7E5, 1'b1, 8'h11);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_lockout();
      write_byte(11'h005, 1'b0, 8'h12);
      read_chk("R7 write accepted after lockout", 11'h005, 1'b0, 8'h12);
      t_write_poll(11'h010, 8'hA5, 8'h00);
      t_write_poll(11'h011, 8'h3C, 8'h80);
      t_latch();
      t_inhibit();
      t_busy_ignore();
      t_id();
      t_clear_short();
      t_clear();
      @(negedge clk);
      oe_n = 1'b0; cs_n = 1'b1;
      #1;
      chk("R2 cs_n high floats bus", int'(dout_en), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule